// File: doc/BRIEF.md
# Multi-Mode Universal Counter Measurement Core

This block is the measuring engine of a reciprocal-style universal counter. It sees two conditioned digital inputs, A and B, a slow reference signal, and a fast counting clock that runs at ten times the reference rate. The mode setting decides which signal drives the main gate and which signal is counted while that gate is open. Frequency measurement gates a decade-scaled reference and counts A. Period measurement gates on A and counts a decade-scaled fast clock. Period averaging gates on a decade-scaled A and counts every fast clock cycle. Time interval measurement opens on A, closes on B, and counts fast clock cycles.

Every measurement runs through the same fixed cycle: armed, gate open, a single-cycle transfer into the result register, a programmable display hold, and a clear. After the clear the block re-arms on its own. The count is kept in BCD decades, so the result can drive a digit display directly. An overflow flag records a wrap of the top decade during the gate.

All three inputs are asynchronous. They are synchronized and edge-detected in the fast clock domain, which is the only clock of the block.

Top module: `univ_counter`

## Requirements
- R1: While reset is asserted and after it is released, result_bcd is zero, result_ovf is 0, xfer is 0, gate_open is 0 and armed is 1.
- R2: With mode = 0 (frequency), the gate spans 10^tb_sel rising edges of ref_in, and the result is the number of rising edges of a_in seen while the gate is open.
- R3: With mode = 1 (period), the gate spans one a_in period, from one rising edge to the next, and the result is floor(P / 10^mult_sel), where P is that period in clk cycles.
- R4: With mode = 2 (period average), the gate spans 10^mult_sel a_in periods, and the result is the total length of those periods in clk cycles.
- R5: With mode = 3 (time interval), a rising edge of a_in opens the gate and a rising edge of b_in closes it. The result is the number of clk cycles between the two edges. A b_in edge while the block is armed is ignored.
- R6: gate_open rises only in the cycle after an opening event seen while armed, and it stays high until the closing event.
- R7: xfer is a one-cycle pulse that directly follows the last gate cycle. result_bcd and result_ovf change only in the cycle after xfer and hold their value otherwise.
- R8: After the xfer cycle the block spends hold_cycles+1 cycles in hold and one cycle in clear. armed therefore rises exactly hold_cycles+3 cycles after xfer.
- R9: If the most significant decade wraps past 9 while the gate is open, result_ovf is 1 for that measurement, and the result holds the count modulo 10^N_DIG. The flag is cleared for the next measurement.
- R10: result_bcd holds one BCD digit per nibble, with digit i at bits [4i+3:4i] (digit 0 least significant). Every nibble is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal at one tenth of the clk rate, asynchronous |
| a_in | input | 1 | Conditioned input A, asynchronous |
| b_in | input | 1 | Conditioned input B, asynchronous |
| mode | input | 2 | 0 frequency, 1 period, 2 period average, 3 time interval |
| tb_sel | input | SEL_W | Time-base decade code, divides the reference by 10^code |
| mult_sel | input | SEL_W | Multiplier decade code, 10^code |
| hold_cycles | input | HOLD_W | Display hold length, in clk cycles minus one |
| result_bcd | output | 4*N_DIG | Last transferred count, BCD |
| result_ovf | output | 1 | Overflow flag transferred with the count |
| xfer | output | 1 | One-cycle transfer pulse |
| gate_open | output | 1 | Main gate is open |
| armed | output | 1 | Waiting for the opening event |

## Verification
The bench runs a three-digit instance and chases the counting boundaries. These are intervals of 999, 1000 and 1005 cycles, where a design with a bad top-decade carry would drop the overflow flag, or would keep it into the next measurement. A lone B edge while armed is sent to catch a gate that opens on the wrong input. Decade codes 0, 1 and 2 are swept in the frequency, period and averaging modes, with periods chosen so that an off-by-one in the prescaler taps, or a prescaler that is not cleared at gate open, shifts the count. The hold length is measured for 0 and 3, which exposes a hold that runs one cycle short or long.

// File: rtl/ucnt_pkg.sv
`timescale 1ns/1ps
package ucnt_pkg;

  typedef enum logic [1:0] {
    MODE_FREQ   = 2'd0,
    MODE_PERIOD = 2'd1,
    MODE_AVG    = 2'd2,
    MODE_TI     = 2'd3
  } meas_mode_e;

  typedef enum logic [2:0] {
    ST_ARM  = 3'd0,
    ST_GATE = 3'd1,
    ST_XFER = 3'd2,
    ST_HOLD = 3'd3,
    ST_CLR  = 3'd4
  } seq_state_e;

  // next value of one decade, wrapping 9 -> 0
  function automatic logic [3:0] bcd_step(input logic [3:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // decade passes a carry on the next increment
  function automatic logic bcd_at_top(input logic [3:0] d);
    return d == 4'd9;
  endfunction

endpackage

// File: rtl/ucnt_sync_edge.sv
`timescale 1ns/1ps
module ucnt_sync_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_ch
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
  end
endmodule

// File: rtl/ucnt_prescaler.sv
`timescale 1ns/1ps
module ucnt_prescaler
  import ucnt_pkg::*;
#(
  parameter int N_STG = 7,
  localparam int SEL_W = $clog2(N_STG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             out_pulse
);
  logic [N_STG:0] en;
  assign en[0] = in_pulse;

  for (genvar i = 0; i < N_STG; i++) begin : g_stg
    logic [3:0] d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     d <= '0;
      else if (clr)   d <= '0;
      else if (en[i]) d <= bcd_step(d);
    end
    assign en[i+1] = en[i] & bcd_at_top(d);
  end

  assign out_pulse = (int'(sel) <= N_STG) ? en[sel] : 1'b0;
endmodule

// File: rtl/ucnt_bcd_counter.sv
`timescale 1ns/1ps
module ucnt_bcd_counter
  import ucnt_pkg::*;
#(
  parameter int N_DIG = 8,
  localparam int CNT_W = 4 * N_DIG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value,
  output logic             carry_out
);
  logic [N_DIG:0] en;
  assign en[0] = inc;

  for (genvar i = 0; i < N_DIG; i++) begin : g_dig
    logic [3:0] d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     d <= '0;
      else if (clr)   d <= '0;
      else if (en[i]) d <= bcd_step(d);
    end
    assign en[i+1]      = en[i] & bcd_at_top(d);
    assign value[4*i+:4] = d;
  end

  assign carry_out = en[N_DIG];
endmodule

// File: rtl/ucnt_meas_seq.sv
`timescale 1ns/1ps
module ucnt_meas_seq
  import ucnt_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_p,
  input  logic              close_p,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              gate_open,
  output logic              xfer,
  output logic              armed,
  output logic              clr_cycle
);
  seq_state_e        st;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_ARM;
      hold_cnt <= '0;
    end else begin
      case (st)
        ST_ARM:  if (open_p) st <= ST_GATE;
        ST_GATE: if (close_p) st <= ST_XFER;
        ST_XFER: begin
          st       <= ST_HOLD;
          hold_cnt <= '0;
        end
        ST_HOLD: begin
          if (hold_cnt >= hold_cycles) st <= ST_CLR;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        ST_CLR:  st <= ST_ARM;
        default: st <= ST_ARM;
      endcase
    end
  end

  assign armed     = (st == ST_ARM);
  assign gate_open = (st == ST_GATE);
  assign xfer      = (st == ST_XFER);
  assign clr_cycle = (st == ST_CLR);
endmodule

// File: rtl/univ_counter.sv
`timescale 1ns/1ps
module univ_counter
  import ucnt_pkg::*;
#(
  parameter int N_DIG  = 8,
  parameter int N_STG  = 7,
  parameter int HOLD_W = 16,
  localparam int SEL_W = $clog2(N_STG + 1),
  localparam int CNT_W = 4 * N_DIG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              a_in,
  input  logic              b_in,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  tb_sel,
  input  logic [SEL_W-1:0]  mult_sel,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic [CNT_W-1:0]  result_bcd,
  output logic              result_ovf,
  output logic              xfer,
  output logic              gate_open,
  output logic              armed
);
  // input edges in the counting clock domain
  logic [2:0] rise;
  logic       ref_p, a_p, b_p;

  ucnt_sync_edge #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({b_in, a_in, ref_in}),
    .rise (rise)
  );
  assign ref_p = rise[0];
  assign a_p   = rise[1];
  assign b_p   = rise[2];

  // routing chosen by the mode
  meas_mode_e       md;
  logic             ctl_in, ctl_div, cnt_fast_div;
  logic [SEL_W-1:0] ctl_sel;
  logic             open_p, close_p, counted;
  logic             cnt_div_out;
  logic             clr_cycle;

  assign md = meas_mode_e'(mode);

  always_comb begin
    ctl_in  = a_p;
    ctl_sel = '0;
    case (md)
      MODE_FREQ:   begin ctl_in = ref_p; ctl_sel = tb_sel;   end
      MODE_PERIOD: begin ctl_in = a_p;   ctl_sel = '0;       end
      MODE_AVG:    begin ctl_in = a_p;   ctl_sel = mult_sel; end
      default:     begin ctl_in = a_p;   ctl_sel = '0;       end
    endcase
  end

  ucnt_prescaler #(.N_STG(N_STG)) u_ctl_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_cycle),
    .in_pulse (ctl_in),
    .sel      (ctl_sel),
    .out_pulse(ctl_div)
  );

  // fast clock scaled by the multiplier, restarted at every gate opening
  ucnt_prescaler #(.N_STG(N_STG)) u_cnt_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~gate_open),
    .in_pulse (1'b1),
    .sel      (mult_sel),
    .out_pulse(cnt_fast_div)
  );
  assign cnt_div_out = cnt_fast_div;

  always_comb begin
    open_p  = ctl_div;
    close_p = ctl_div;
    counted = 1'b1;
    case (md)
      MODE_FREQ:   counted = a_p;
      MODE_PERIOD: counted = cnt_div_out;
      MODE_AVG:    counted = 1'b1;
      default: begin
        open_p  = a_p;
        close_p = b_p;
        counted = 1'b1;
      end
    endcase
  end

  ucnt_meas_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_p     (open_p),
    .close_p    (close_p),
    .hold_cycles(hold_cycles),
    .gate_open  (gate_open),
    .xfer       (xfer),
    .armed      (armed),
    .clr_cycle  (clr_cycle)
  );

  // decade counters and overflow
  logic [CNT_W-1:0] count_bcd;
  logic             top_carry, ovf_hit, ovf_q;

  ucnt_bcd_counter #(.N_DIG(N_DIG)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_cycle),
    .inc      (gate_open & counted),
    .value    (count_bcd),
    .carry_out(top_carry)
  );

  assign ovf_hit = top_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (clr_cycle) ovf_q <= 1'b0;
    else if (ovf_hit)   ovf_q <= 1'b1;
  end

  // result memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_bcd <= '0;
      result_ovf <= 1'b0;
    end else if (xfer) begin
      result_bcd <= count_bcd;
      result_ovf <= ovf_q;
    end
  end
endmodule

// File: rtl/ucnt_chk.sv
`timescale 1ns/1ps
module ucnt_chk #(
  parameter int N_DIG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4*N_DIG-1:0] result_bcd,
  input logic             result_ovf,
  input logic             xfer,
  input logic             gate_open,
  input logic             armed,
  input logic             open_p,
  input logic             clr_cycle,
  input logic             ovf_hit
);
  function automatic logic digits_legal(input logic [4*N_DIG-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N_DIG; i++) if (v[4*i+:4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R7
  xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);

  // R7
  xfer_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> $past(gate_open));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({result_ovf, result_bcd}) |-> $past(xfer));

  // R6
  gate_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> $past(armed && open_p));

  // R8
  arm_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(clr_cycle));

  // R9
  ovf_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |-> gate_open);

  // R10
  bcd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digits_legal(result_bcd));
endmodule

bind univ_counter ucnt_chk #(.N_DIG(N_DIG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .result_bcd(result_bcd),
  .result_ovf(result_ovf),
  .xfer      (xfer),
  .gate_open (gate_open),
  .armed     (armed),
  .open_p    (open_p),
  .clr_cycle (clr_cycle),
  .ovf_hit   (ovf_hit)
);

// File: tb/tb_univ_counter.sv
`timescale 1ns/1ps
module tb_univ_counter;
  localparam int ND = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic        a_free = 1'b0, a_man = 1'b0, b_man = 1'b0;
  logic        ti_sel = 1'b1;
  logic [1:0]  mode = 2'd3;
  logic [2:0]  tb_sel = 3'd0, mult_sel = 3'd0;
  logic [15:0] hold_cycles = 16'd3;
  logic [4*ND-1:0] result_bcd;
  logic        result_ovf, xfer, gate_open, armed;
  int          a_half = 10;
  int          n_chk = 0, n_bad = 0;

  univ_counter #(.N_DIG(ND), .N_STG(7), .HOLD_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .a_in(ti_sel ? a_man : a_free), .b_in(b_man),
    .mode(mode), .tb_sel(tb_sel), .mult_sel(mult_sel),
    .hold_cycles(hold_cycles), .result_bcd(result_bcd),
    .result_ovf(result_ovf), .xfer(xfer), .gate_open(gate_open), .armed(armed)
  );

  always #5 clk = ~clk;

  initial begin
    #3;
    forever #50 ref_in = ~ref_in;
  end

  initial begin
    #3;
    forever #(a_half * 10) a_free = ~a_free;
  end

  function automatic logic [4*ND-1:0] to_bcd(input int v);
    logic [4*ND-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < ND; i++) begin
      r[4*i+:4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_xfer();
    int k;
    k = 0;
    while (!xfer && k < 30000) begin @(negedge clk); k++; end
    if (!xfer) check(1'b0, "xfer-timeout", 0, 1);
  endtask

  task automatic wait_armed();
    int k;
    k = 0;
    while (!armed && k < 30000) begin @(negedge clk); k++; end
  endtask

  // measure a time interval of d cycles in mode 3
  task automatic run_ti(input int d, input int exp_val, input bit exp_ovf, input int hold_exp);
    int k;
    wait_armed();
    @(negedge clk);
    a_man = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      if (i == 1) a_man = 1'b0;
      // R6: gate open in the middle of the interval
      if (i == 12) check(gate_open === 1'b1, "R6 gate open", int'(gate_open), 1);
    end
    b_man = 1'b1;
    repeat (2) @(negedge clk);
    b_man = 1'b0;
    wait_xfer();
    @(negedge clk);
    check(xfer === 1'b0, "R7 single xfer", int'(xfer), 0);
    // R5 R9 R10
    check(result_bcd === to_bcd(exp_val) && result_ovf === exp_ovf, "R5/R9 interval",
          int'({result_ovf, result_bcd}), int'({exp_ovf, to_bcd(exp_val)}));
    k = 1;
    while (!armed && k < 1000) begin @(negedge clk); k++; end
    check(k == hold_exp, "R8 hold length", k, hold_exp);
  endtask

  // free-running measurement: discard one, check the next
  task automatic run_free(input int exp_val, input string req);
    wait_xfer();
    @(negedge clk);
    wait_xfer();
    @(negedge clk);
    check(result_bcd === to_bcd(exp_val) && result_ovf === 1'b0, req,
          int'(result_bcd), int'(to_bcd(exp_val)));
  endtask

  initial begin
    #1_900_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(result_bcd === '0 && result_ovf === 1'b0 && xfer === 1'b0 && gate_open === 1'b0
          && armed === 1'b1, "R1 reset", int'({xfer, gate_open, armed}), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(result_bcd === '0 && result_ovf === 1'b0 && xfer === 1'b0 && gate_open === 1'b0
          && armed === 1'b1, "R1 after reset", int'({xfer, gate_open, armed}), 1);

    // R5: a lone B edge while armed must not open the gate
    b_man = 1'b1;
    repeat (2) @(negedge clk);
    b_man = 1'b0;
    repeat (10) @(negedge clk);
    check(gate_open === 1'b0 && armed === 1'b1, "R5 B ignored", int'(gate_open), 0);

    run_ti(137, 137, 1'b0, 6);
    run_ti(999, 999, 1'b0, 6);
    run_ti(1000, 0, 1'b1, 6);
    hold_cycles = 16'd0;
    run_ti(1005, 5, 1'b1, 3);
    run_ti(40, 40, 1'b0, 3);
    hold_cycles = 16'd3;

    // R2 frequency
    ti_sel = 1'b0;
    mode = 2'd0;
    tb_sel = 3'd1; a_half = 10;
    run_free(5, "R2 freq tb1");
    tb_sel = 3'd2; a_half = 4;
    run_free(125, "R2 freq tb2");

    // R3 period
    mode = 2'd1;
    mult_sel = 3'd0; a_half = 28;
    run_free(56, "R3 period m0");
    mult_sel = 3'd1;
    run_free(5, "R3 period m1");
    mult_sel = 3'd2; a_half = 125;
    run_free(2, "R3 period m2");

    // R4 period average
    mode = 2'd2;
    mult_sel = 3'd1; a_half = 12;
    run_free(240, "R4 average m1");
    mult_sel = 3'd0; a_half = 28;
    run_free(56, "R4 average m0");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule